// File: doc/BRIEF.md
# Indexed Register Access Window

This block gives a host a narrow two-word I/O window onto the much larger 32-bit register file of a storage host controller. The host first writes a register number into the index word of the window, at window byte offset 0. Every later read or write of the data word, at window byte offset 4, is then routed to the register that the stored index names. The index stays put until the host writes it again, so a read-modify-write takes one index write, one data read and one data write.

The index space is split into a global bank and a row of per-port banks. Indexes below 0x100 belong to the global bank. From 0x100 upward each port owns a slice of 0x80 bytes, so a port register lives at index 0x100 + port*0x80 + offset. The window decodes the stored index, raises exactly one read or write strobe toward the selected bank in the same cycle as the data access, passes the bank-relative byte offset and the write data along, and returns the selected bank's read data. Indexes that name no implemented register are harmless: they read as zero and drop writes. The side effects of individual registers (clear-on-write bits and the like) live in the banks, not here.

Top module: `idxwin_top`

## Requirements
- R1: After reset the index word reads as 0; a write to window byte offset 0 loads the index, and a read of offset 0 returns the last value loaded, in the same cycle as the read.
- R2: A data access (window byte offset 4) whose index is a global register raises `glb_rd` (read) or `glb_wr` (write) for that cycle with `tgt_off` equal to the index; a read returns `glb_rdata`. Implemented global indexes are 0x00, 0x04, 0x08, 0x0C and 0x10.
- R3: A data access whose index is 0x100 + p*0x80 + o, with p below `NUM_PORTS` and o an implemented port offset, raises bit p of `port_rd` or `port_wr` with `tgt_off` = o; a read returns bits [p*32+31:p*32] of `port_rdata`. Implemented port offsets are 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34 and 0x38.
- R4: A data access whose index is not a multiple of 4, is an unlisted global index, or is an unlisted port offset (such as 0x1C or 0x3C..0x7C) raises no strobe and reads as zero.
- R5: A data access whose index decodes to a port number at or above `NUM_PORTS` raises no strobe and reads as zero.
- R6: At most one of all bank strobes is high in any cycle, and a strobe is high only in a cycle with a valid data access of the matching direction.
- R7: Data reads and data writes leave the index unchanged, so a read followed by a write reaches the same register.
- R8: An access at any window offset other than 0 and 4 raises no strobe, reads as zero and leaves the index unchanged.
- R9: During a write strobe `tgt_wdata` equals the write data of the window access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_valid | input | 1 | Window access in this cycle |
| win_write | input | 1 | 1 = write, 0 = read |
| win_addr | input | 3 | Window byte offset (0 index, 4 data) |
| win_wdata | input | 32 | Write data from host |
| win_rdata | output | 32 | Read data to host, valid in the access cycle |
| glb_rd | output | 1 | Read strobe to global bank |
| glb_wr | output | 1 | Write strobe to global bank |
| port_rd | output | NUM_PORTS | Read strobes, one per port bank |
| port_wr | output | NUM_PORTS | Write strobes, one per port bank |
| tgt_off | output | 8 | Byte offset within the selected bank |
| tgt_wdata | output | 32 | Write data to banks |
| glb_rdata | input | 32 | Read data from global bank |
| port_rdata | input | NUM_PORTS*32 | Read data from port banks, port p in slice p |

## Verification
The hardest situation to reach is an index that lands just past a valid decode boundary: the last implemented port offset versus the holes beside it, the first index of the port after the last implemented one, and the wrap of a huge index through the port subtraction. The stimulus table writes each of these indexes through the window and then performs both a data read and a data write, so every boundary is seen in both directions with the strobe vector and read data compared. A directed read-modify-write sequence then confirms that the index survives the data accesses between them.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;

    localparam int WORD_W = 32;
    localparam int OFF_W  = 8;
    localparam int PNUM_W = 8;
    localparam int WADDR_W = 3;

    localparam logic [WADDR_W-1:0] WIN_OFF_INDEX = 3'd0;
    localparam logic [WADDR_W-1:0] WIN_OFF_DATA  = 3'd4;

    typedef enum logic [1:0] {
        BANK_NONE   = 2'd0,
        BANK_GLOBAL = 2'd1,
        BANK_PORT   = 2'd2
    } bank_e;

    typedef struct packed {
        bank_e             bank;
        logic [PNUM_W-1:0] pnum;
        logic [OFF_W-1:0]  off;
    } bank_sel_t;

    typedef struct packed {
        logic idx_rd;
        logic idx_wr;
        logic dat_rd;
        logic dat_wr;
    } acc_kind_t;

    // Global registers that exist in the bank
    function automatic logic glb_present(input logic [OFF_W-1:0] off);
        case (off)
            8'h00, 8'h04, 8'h08, 8'h0C, 8'h10: glb_present = 1'b1;
            default:                           glb_present = 1'b0;
        endcase
    endfunction

    // Per-port registers that exist in each port bank
    function automatic logic port_present(input logic [OFF_W-1:0] off);
        case (off)
            8'h00, 8'h04, 8'h08, 8'h0C,
            8'h10, 8'h14, 8'h18,
            8'h20, 8'h24, 8'h28, 8'h2C,
            8'h30, 8'h34, 8'h38:           port_present = 1'b1;
            default:                       port_present = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/idxwin_access_class.sv
module idxwin_access_class
    import idxwin_pkg::*;
(
    input  logic               valid,
    input  logic               write,
    input  logic [WADDR_W-1:0] addr,
    output acc_kind_t          kind
);
    logic hit_idx;
    logic hit_dat;

    always_comb begin
        hit_idx     = valid && (addr == WIN_OFF_INDEX);
        hit_dat     = valid && (addr == WIN_OFF_DATA);
        kind.idx_rd = hit_idx && !write;
        kind.idx_wr = hit_idx && write;
        kind.dat_rd = hit_dat && !write;
        kind.dat_wr = hit_dat && write;
    end
endmodule

// File: rtl/idxwin_index_reg.sv
module idxwin_index_reg
    import idxwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/idxwin_decoder.sv
module idxwin_decoder
    import idxwin_pkg::*;
#(
    parameter int          NUM_PORTS    = 4,
    parameter logic [31:0] GLB_SPAN     = 32'h100,
    parameter int          STRIDE_LG2   = 7
) (
    input  logic [WORD_W-1:0] idx,
    output bank_sel_t         sel
);
    localparam logic [WORD_W-1:0] PORT_MASK = WORD_W'((64'd1 << STRIDE_LG2) - 64'd1);
    localparam logic [WORD_W-1:0] PORT_LIM  = WORD_W'(NUM_PORTS);

    logic [WORD_W-1:0] rel;
    logic [WORD_W-1:0] pnum_full;
    logic [WORD_W-1:0] poff_full;
    logic              aligned;

    always_comb begin
        rel       = idx - GLB_SPAN;
        pnum_full = rel >> STRIDE_LG2;
        poff_full = rel & PORT_MASK;
        aligned   = (idx[1:0] == 2'b00);
        sel       = '{bank: BANK_NONE, pnum: '0, off: '0};
        if (aligned) begin
            if (idx < GLB_SPAN) begin
                if (glb_present(idx[OFF_W-1:0])) begin
                    sel.bank = BANK_GLOBAL;
                    sel.off  = idx[OFF_W-1:0];
                end
            end else if (pnum_full < PORT_LIM) begin
                if (port_present(poff_full[OFF_W-1:0])) begin
                    sel.bank = BANK_PORT;
                    sel.pnum = pnum_full[PNUM_W-1:0];
                    sel.off  = poff_full[OFF_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/idxwin_bank_route.sv
module idxwin_bank_route
    import idxwin_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                        dat_rd,
    input  logic                        dat_wr,
    input  bank_sel_t                   sel,
    input  logic [WORD_W-1:0]           glb_rdata,
    input  logic [NUM_PORTS*WORD_W-1:0] port_rdata,
    output logic                        glb_rd,
    output logic                        glb_wr,
    output logic [NUM_PORTS-1:0]        port_rd,
    output logic [NUM_PORTS-1:0]        port_wr,
    output logic [OFF_W-1:0]            tgt_off,
    output logic [WORD_W-1:0]           bank_rdata
);
    logic                 to_glb;
    logic [NUM_PORTS-1:0] to_port;
    logic [WORD_W-1:0]    port_mux [NUM_PORTS+1];

    assign to_glb  = (sel.bank == BANK_GLOBAL);
    assign glb_rd  = dat_rd && to_glb;
    assign glb_wr  = dat_wr && to_glb;
    assign tgt_off = sel.off;

    assign port_mux[0] = '0;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign to_port[p]    = (sel.bank == BANK_PORT) && (sel.pnum == PNUM_W'(p));
        assign port_rd[p]    = dat_rd && to_port[p];
        assign port_wr[p]    = dat_wr && to_port[p];
        assign port_mux[p+1] = port_mux[p]
                             | (to_port[p] ? port_rdata[p*WORD_W +: WORD_W] : '0);
    end

    always_comb begin
        bank_rdata = '0;
        if (dat_rd) begin
            if (to_glb) begin
                bank_rdata = glb_rdata;
            end else begin
                bank_rdata = port_mux[NUM_PORTS];
            end
        end
    end
endmodule

// File: rtl/idxwin_top.sv
module idxwin_top
    import idxwin_pkg::*;
#(
    parameter int          NUM_PORTS  = 4,
    parameter logic [31:0] GLB_SPAN   = 32'h100,
    parameter int          STRIDE_LG2 = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        win_valid,
    input  logic                        win_write,
    input  logic [2:0]                  win_addr,
    input  logic [31:0]                 win_wdata,
    output logic [31:0]                 win_rdata,
    output logic                        glb_rd,
    output logic                        glb_wr,
    output logic [NUM_PORTS-1:0]        port_rd,
    output logic [NUM_PORTS-1:0]        port_wr,
    output logic [7:0]                  tgt_off,
    output logic [31:0]                 tgt_wdata,
    input  logic [31:0]                 glb_rdata,
    input  logic [NUM_PORTS*32-1:0]     port_rdata
);
    acc_kind_t         kind;
    logic [WORD_W-1:0] idx_q;
    bank_sel_t         sel;
    logic [WORD_W-1:0] bank_rdata;

    idxwin_access_class u_class (
        .valid (win_valid),
        .write (win_write),
        .addr  (win_addr),
        .kind  (kind)
    );

    idxwin_index_reg u_index (
        .clk  (clk),
        .rst  (rst),
        .load (kind.idx_wr),
        .din  (win_wdata),
        .q    (idx_q)
    );

    idxwin_decoder #(
        .NUM_PORTS  (NUM_PORTS),
        .GLB_SPAN   (GLB_SPAN),
        .STRIDE_LG2 (STRIDE_LG2)
    ) u_dec (
        .idx (idx_q),
        .sel (sel)
    );

    idxwin_bank_route #(
        .NUM_PORTS (NUM_PORTS)
    ) u_route (
        .dat_rd     (kind.dat_rd),
        .dat_wr     (kind.dat_wr),
        .sel        (sel),
        .glb_rdata  (glb_rdata),
        .port_rdata (port_rdata),
        .glb_rd     (glb_rd),
        .glb_wr     (glb_wr),
        .port_rd    (port_rd),
        .port_wr    (port_wr),
        .tgt_off    (tgt_off),
        .bank_rdata (bank_rdata)
    );

    assign tgt_wdata = win_wdata;

    always_comb begin
        if (kind.idx_rd) begin
            win_rdata = idx_q;
        end else if (kind.dat_rd) begin
            win_rdata = bank_rdata;
        end else begin
            win_rdata = '0;
        end
    end
endmodule

// File: rtl/idxwin_chk.sv
module idxwin_chk #(
    parameter int NUM_PORTS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 win_valid,
    input logic                 win_write,
    input logic [2:0]           win_addr,
    input logic [31:0]          win_wdata,
    input logic [31:0]          win_rdata,
    input logic                 glb_rd,
    input logic                 glb_wr,
    input logic [NUM_PORTS-1:0] port_rd,
    input logic [NUM_PORTS-1:0] port_wr,
    input logic [31:0]          tgt_wdata,
    input logic [31:0]          idx_q
);
    logic any_rd;
    logic any_wr;
    logic idx_load;

    assign any_rd   = glb_rd || (|port_rd);
    assign any_wr   = glb_wr || (|port_wr);
    assign idx_load = win_valid && win_write && (win_addr == 3'd0);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $countones({glb_rd, glb_wr, port_rd, port_wr}) <= 1); // R6

    AST_RD_NEEDS_DATA_READ: assert property (@(posedge clk) disable iff (rst)
        any_rd |-> (win_valid && !win_write && win_addr == 3'd4)); // R6

    AST_WR_NEEDS_DATA_WRITE: assert property (@(posedge clk) disable iff (rst)
        any_wr |-> (win_valid && win_write && win_addr == 3'd4)); // R6

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
        idx_load |=> (idx_q == $past(win_wdata))); // R1

    AST_INDEX_READBACK: assert property (@(posedge clk) disable iff (rst)
        (win_valid && !win_write && win_addr == 3'd0) |-> (win_rdata == idx_q)); // R1

    AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !idx_load |=> $stable(idx_q)); // R7

    AST_UNSEL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (win_valid && !win_write && win_addr == 3'd4 && !any_rd) |-> (win_rdata == 32'h0)); // R4

    AST_OTHER_OFFSET_ZERO: assert property (@(posedge clk) disable iff (rst)
        (win_valid && win_addr != 3'd0 && win_addr != 3'd4) |-> (win_rdata == 32'h0 && !any_rd && !any_wr)); // R8

    AST_WDATA_FORWARD: assert property (@(posedge clk) disable iff (rst)
        any_wr |-> (tgt_wdata == win_wdata)); // R9
endmodule

bind idxwin_top idxwin_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .win_valid (win_valid),
    .win_write (win_write),
    .win_addr  (win_addr),
    .win_wdata (win_wdata),
    .win_rdata (win_rdata),
    .glb_rd    (glb_rd),
    .glb_wr    (glb_wr),
    .port_rd   (port_rd),
    .port_wr   (port_wr),
    .tgt_wdata (tgt_wdata),
    .idx_q     (idx_q)
);

// File: tb/idxwin_top_tb_top.sv
module idxwin_top_tb_top;
    localparam int NP = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              win_valid;
    logic              win_write;
    logic [2:0]        win_addr;
    logic [31:0]       win_wdata;
    logic [31:0]       win_rdata;
    logic              glb_rd, glb_wr;
    logic [NP-1:0]     port_rd, port_wr;
    logic [7:0]        tgt_off;
    logic [31:0]       tgt_wdata;
    logic [31:0]       glb_rdata;
    logic [NP*32-1:0]  port_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    // Bank models: read data encodes bank and offset
    assign glb_rdata = 32'hC0DE_0000 | {24'h0, tgt_off};
    for (genvar p = 0; p < NP; p++) begin : g_bank
        assign port_rdata[p*32 +: 32] = 32'h5000_0000 | (32'(p) << 16) | {24'h0, tgt_off};
    end

    idxwin_top #(.NUM_PORTS(NP)) dut_i (
        .clk(clk), .rst(rst), .win_valid(win_valid), .win_write(win_write),
        .win_addr(win_addr), .win_wdata(win_wdata), .win_rdata(win_rdata),
        .glb_rd(glb_rd), .glb_wr(glb_wr), .port_rd(port_rd), .port_wr(port_wr),
        .tgt_off(tgt_off), .tgt_wdata(tgt_wdata),
        .glb_rdata(glb_rdata), .port_rdata(port_rdata)
    );

    // kind: 0 none, 1 global, 2 port
    typedef struct packed {
        logic [31:0] idx;
        logic [1:0]  kind;
        logic [7:0]  pnum;
        logic [7:0]  off;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_0000, 2'd1, 8'd0, 8'h00},   // R2
        '{32'h0000_0004, 2'd1, 8'd0, 8'h04},   // R2
        '{32'h0000_0008, 2'd1, 8'd0, 8'h08},   // R2
        '{32'h0000_000C, 2'd1, 8'd0, 8'h0C},   // R2
        '{32'h0000_0010, 2'd1, 8'd0, 8'h10},   // R2
        '{32'h0000_0014, 2'd0, 8'd0, 8'h00},   // R4
        '{32'h0000_00FC, 2'd0, 8'd0, 8'h00},   // R4
        '{32'h0000_0002, 2'd0, 8'd0, 8'h00},   // R4 misaligned
        '{32'h0000_0100, 2'd2, 8'd0, 8'h00},   // R3
        '{32'h0000_0138, 2'd2, 8'd0, 8'h38},   // R3
        '{32'h0000_011C, 2'd0, 8'd0, 8'h00},   // R4
        '{32'h0000_013C, 2'd0, 8'd0, 8'h00},   // R4
        '{32'h0000_0198, 2'd2, 8'd1, 8'h18},   // R3
        '{32'h0000_0220, 2'd2, 8'd2, 8'h20},   // R3
        '{32'h0000_02B4, 2'd2, 8'd3, 8'h34},   // R3
        '{32'h0000_0300, 2'd0, 8'd0, 8'h00},   // R5
        '{32'h0000_0378, 2'd0, 8'd0, 8'h00},   // R5
        '{32'hFFFF_FF00, 2'd0, 8'd0, 8'h00}    // R5
    };

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic w, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        win_valid = v; win_write = w; win_addr = a; win_wdata = d;
        #1;
    endtask

    function automatic logic [11:0] strobes();
        return {glb_rd, glb_wr, 2'b00, port_rd, port_wr};
    endfunction

    function automatic logic [11:0] exp_strobes(input logic [1:0] kind, input logic [7:0] pn, input logic wr);
        logic [11:0] s;
        s = '0;
        if (kind == 2'd1) s[wr ? 10 : 11] = 1'b1;
        if (kind == 2'd2) s[(wr ? 0 : NP) + int'(pn)] = 1'b1;
        return s;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [1:0] kind, input logic [7:0] pn, input logic [7:0] off);
        if (kind == 2'd1) return 32'hC0DE_0000 | {24'h0, off};
        if (kind == 2'd2) return 32'h5000_0000 | ({24'h0, pn} << 16) | {24'h0, off};
        return 32'h0;
    endfunction

    initial begin
        #(200000 * 10);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; win_valid = 1'b0; win_write = 1'b0; win_addr = 3'd0; win_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset value of index
        drive(1'b1, 1'b0, 3'd0, 32'h0);
        check(win_rdata == 32'h0, "R1 reset index", 64'(win_rdata), 64'h0);

        // Table walk: index write, data read, data write
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            drive(1'b1, 1'b1, 3'd0, v.idx);
            drive(1'b1, 1'b0, 3'd4, 32'h0);
            check(strobes() == exp_strobes(v.kind, v.pnum, 1'b0), "R2/R3/R4/R5/R6 read strobes",
                  64'(strobes()), 64'(exp_strobes(v.kind, v.pnum, 1'b0)));
            check(win_rdata == exp_rd(v.kind, v.pnum, v.off), "R2/R3/R4/R5 read data",
                  64'(win_rdata), 64'(exp_rd(v.kind, v.pnum, v.off)));
            if (v.kind != 2'd0)
                check(tgt_off == v.off, "R2/R3 offset", 64'(tgt_off), 64'(v.off));
            drive(1'b1, 1'b1, 3'd4, 32'hA5A5_0000 | 32'(i));
            check(strobes() == exp_strobes(v.kind, v.pnum, 1'b1), "R2/R3/R4/R5/R6 write strobes",
                  64'(strobes()), 64'(exp_strobes(v.kind, v.pnum, 1'b1)));
            if (v.kind != 2'd0)
                check(tgt_wdata == (32'hA5A5_0000 | 32'(i)), "R9 write data",
                      64'(tgt_wdata), 64'(32'hA5A5_0000 | 32'(i)));
        end

        // R1 readback of arbitrary index
        drive(1'b1, 1'b1, 3'd0, 32'hDEAD_BEEF);
        drive(1'b1, 1'b0, 3'd0, 32'h0);
        check(win_rdata == 32'hDEAD_BEEF, "R1 index readback", 64'(win_rdata), 64'hDEAD_BEEF);

        // R7 read-modify-write of port 1 command register
        drive(1'b1, 1'b1, 3'd0, 32'h0000_0198);
        drive(1'b1, 1'b0, 3'd4, 32'h0);
        check(port_rd == 4'b0010 && win_rdata == 32'h5001_0018, "R7 rmw read",
              64'(win_rdata), 64'h5001_0018);
        drive(1'b1, 1'b1, 3'd4, 32'h5001_0019);
        check(port_wr == 4'b0010 && tgt_off == 8'h18 && tgt_wdata == 32'h5001_0019, "R7 rmw write",
              64'({port_wr, tgt_off}), 64'({4'b0010, 8'h18}));
        drive(1'b1, 1'b0, 3'd0, 32'h0);
        check(win_rdata == 32'h0000_0198, "R7 index kept", 64'(win_rdata), 64'h198);

        // R8 other window offsets
        drive(1'b1, 1'b1, 3'd2, 32'h1234_5678);
        check(strobes() == 12'h0, "R8 write other offset strobes", 64'(strobes()), 64'h0);
        drive(1'b1, 1'b0, 3'd6, 32'h0);
        check(win_rdata == 32'h0 && strobes() == 12'h0, "R8 read other offset", 64'(win_rdata), 64'h0);
        drive(1'b1, 1'b0, 3'd0, 32'h0);
        check(win_rdata == 32'h0000_0198, "R8 index unchanged", 64'(win_rdata), 64'h198);

        // R6 no strobe without valid
        drive(1'b0, 1'b1, 3'd4, 32'hFFFF_FFFF);
        check(strobes() == 12'h0 && win_rdata == 32'h0, "R6 idle no strobe", 64'(strobes()), 64'h0);

        // R1 reset clears index again
        @(negedge clk) rst = 1'b1; win_valid = 1'b0;
        @(negedge clk) rst = 1'b0;
        drive(1'b1, 1'b0, 3'd0, 32'h0);
        check(win_rdata == 32'h0, "R1 index after second reset", 64'(win_rdata), 64'h0);

        drive(1'b0, 1'b0, 3'd0, 32'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule